// File: doc/BRIEF.md
# GPIO Expander Register Bank

This block is the register core of a small general-purpose I/O port expander. A serial bus front end, which is not part of this block, has already turned bus traffic into four byte-level events: a transaction start, a byte written with its data, a request for one byte of read data, and a transaction stop. The core keeps a register pointer and four registers. These are a pin input view, an output latch, a per-pin polarity inversion mask and a per-pin direction mask. From them it drives an output value and an output enable for each pin.

The first byte written after a start selects the register. Any further bytes written in the same transaction land in that register. To read a register, the host first sends a transaction that carries only the pointer byte, and then issues read requests. The pointer never advances on its own, so repeated accesses all hit the same register. Pin levels pass through a synchronizer before the input view sees them. Inversion applies only to pins that are set as inputs.

Top module: `gpio_xpdr_core`

## Requirements
- R1: After reset, the output latch reads 0xFF, the inversion mask reads 0x00 and the direction mask reads 0xFF. As a result, `pin_oe` is all zero, `pin_out` is 0xFF and `host_rd_data` is 0x00.
- R2: The first byte written after `host_start` is stored as the register pointer. Pointer values are: 0 for the input view, 1 for the output latch, 2 for the inversion mask and 3 for the direction mask. Later bytes written in that transaction update the selected register.
- R3: A read request captures the selected register into `host_rd_data` at the clock edge where the request is sampled. The value is visible in the following cycle. Without a request, `host_rd_data` holds its value.
- R4: The input view reports every pin, whatever its direction. Pin levels pass through a two-flop synchronizer, so a read request sampled at the third rising edge after a pin change returns the new level, and requests at the first two edges return the old level.
- R5: A 1 in the inversion mask inverts the reported level of that pin only when its direction bit is 1 (input). Pins set as outputs are reported without inversion.
- R6: Writes while the pointer is 0 change no register.
- R7: Reading pointer 1 returns the output latch, not the level on the pin.
- R8: Direction bit 1 makes that pin an input with `pin_oe` low. Direction bit 0 drives `pin_oe` high, and `pin_out` carries the latch bit.
- R9: A pointer value above 3 is stored. Writes to it are ignored, and reads from it return 0x00.
- R10: The pointer does not advance. Consecutive data bytes all go to the same register.
- R11: After `host_stop`, and before the next `host_start`, written bytes are ignored and leave both the pointer and the registers unchanged. The pointer is kept across the stop for later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_start | input | 1 | Transaction start pulse |
| host_stop | input | 1 | Transaction stop pulse |
| host_wr_vld | input | 1 | Written byte strobe |
| host_wr_data | input | 8 | Written byte |
| host_rd_req | input | 1 | Read byte request |
| host_rd_data | output | 8 | Read byte, valid the cycle after the request |
| pin_in | input | PIN_W | Sampled pin levels |
| pin_out | output | PIN_W | Pin output values |
| pin_oe | output | PIN_W | Pin output enables, high drives |

## Verification
The bench goes after these corner cases:
- **Mixed directions with inversion.** A mask that is all ones is applied while the direction mask mixes inputs and outputs. A design that inverts output pins reports flipped bits there.
- **Output latch against a driving pin.** The latch is read while the pin carries a different level. A design that returns the pin instead of the latch fails this check.
- **Synchronizer latency.** Read requests are issued on the first, second and third edges after a pin change. A design with the wrong number of synchronizer stages returns the new value too early or too late.
- **Ignored writes and repeated bytes.** Out-of-range pointers, writes to the input view, writes after a stop and repeated data bytes are each followed by reads of every register. A design that auto-increments the pointer or accepts these writes shows corrupted registers.

// File: rtl/gpio_xpdr_pkg.sv
package gpio_xpdr_pkg;
   localparam int BYTE_W   = 8;
   localparam int NUM_REGS = 4;
   localparam int SEL_W    = $clog2(NUM_REGS);

   typedef enum logic [SEL_W-1:0] {
      SEL_INPUT  = 2'd0,
      SEL_OUTPUT = 2'd1,
      SEL_POLAR  = 2'd2,
      SEL_DIR    = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_xpdr_sync.sv
module gpio_xpdr_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_xpdr_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpio_xpdr_sync: W must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_xpdr_cmd.sv
module gpio_xpdr_cmd
   import gpio_xpdr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_start,
   input  logic              host_stop,
   input  logic              host_wr_vld,
   input  logic [BYTE_W-1:0] host_wr_data,
   output logic [BYTE_W-1:0] ptr_q,
   output logic              data_wr
);
   logic in_txn_q;
   logic await_cmd_q;
   logic ptr_load;

   assign ptr_load = host_wr_vld & in_txn_q & await_cmd_q & ~host_start & ~host_stop;
   assign data_wr  = host_wr_vld & in_txn_q & ~await_cmd_q & ~host_start & ~host_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_txn_q    <= 1'b0;
         await_cmd_q <= 1'b0;
         ptr_q       <= '0;
      end else if (host_start) begin
         in_txn_q    <= 1'b1;
         await_cmd_q <= 1'b1;
      end else if (host_stop) begin
         in_txn_q    <= 1'b0;
         await_cmd_q <= 1'b0;
      end else if (ptr_load) begin
         ptr_q       <= host_wr_data;
         await_cmd_q <= 1'b0;
      end
   end

   // R2
   ptr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_vld && in_txn_q && await_cmd_q && !host_start && !host_stop)
      |=> (ptr_q == $past(host_wr_data)));

   // R11
   idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_txn_q && !host_start && host_wr_vld) |=> $stable(ptr_q));

   // R10
   no_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr) |=> $stable(ptr_q));
endmodule

// File: rtl/gpio_xpdr_regs.sv
module gpio_xpdr_regs
   import gpio_xpdr_pkg::*;
#(
   parameter int               PIN_W   = 8,
   parameter logic [PIN_W-1:0] OUT_RST = '1,
   parameter logic [PIN_W-1:0] POL_RST = '0,
   parameter logic [PIN_W-1:0] DIR_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] ptr_q,
   input  logic              data_wr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_req,
   input  logic [PIN_W-1:0]  pin_sync,
   output logic [PIN_W-1:0]  out_q,
   output logic [PIN_W-1:0]  dir_q,
   output logic [BYTE_W-1:0] rd_data
);
   localparam int PAD = BYTE_W - PIN_W;

   if (PIN_W < 1 || PIN_W > BYTE_W) begin : g_bad_pins
      $error("gpio_xpdr_regs: PIN_W must lie in 1..BYTE_W");
   end

   logic [PIN_W-1:0]  pol_q;
   logic [PIN_W-1:0]  in_view;
   logic [PIN_W-1:0]  rd_mux;
   logic [BYTE_W-1:0] rd_word;
   logic [PIN_W-1:0]  wr_bits;
   logic              ptr_ok;
   reg_sel_e          sel;

   assign ptr_ok  = (ptr_q < BYTE_W'(NUM_REGS));
   assign sel     = reg_sel_e'(ptr_q[SEL_W-1:0]);
   assign wr_bits = wr_data[PIN_W-1:0];

   if (PAD > 0) begin : g_unused_hi
      logic unused_hi;
      assign unused_hi = ^wr_data[BYTE_W-1:PIN_W];
   end

   // inversion only on pins set as inputs
   assign in_view = pin_sync ^ (pol_q & dir_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= OUT_RST;
         pol_q <= POL_RST;
         dir_q <= DIR_RST;
      end else if (data_wr && ptr_ok) begin
         unique case (sel)
            SEL_OUTPUT: out_q <= wr_bits;
            SEL_POLAR:  pol_q <= wr_bits;
            SEL_DIR:    dir_q <= wr_bits;
            default:    ;
         endcase
      end
   end

   always_comb begin
      rd_mux = '0;
      if (ptr_ok) begin
         unique case (sel)
            SEL_INPUT:  rd_mux = in_view;
            SEL_OUTPUT: rd_mux = out_q;
            SEL_POLAR:  rd_mux = pol_q;
            SEL_DIR:    rd_mux = dir_q;
            default:    rd_mux = '0;
         endcase
      end
   end

   if (PAD == 0) begin : g_full
      assign rd_word = rd_mux;
   end else begin : g_padded
      assign rd_word = {{PAD{1'b0}}, rd_mux};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_req) rd_data <= rd_word;
   end

   // R3
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rd_data));

   // R6
   input_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && ptr_q == '0) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

   // R9
   oob_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !ptr_ok) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

   // R9
   oob_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !ptr_ok) |=> (rd_data == '0));

   // R7
   out_latch_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && ptr_q == BYTE_W'(1)) |=> (rd_data[PIN_W-1:0] == $past(out_q)));
endmodule

// File: rtl/gpio_xpdr_core.sv
module gpio_xpdr_core
   import gpio_xpdr_pkg::*;
#(
   parameter int               PIN_W       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [PIN_W-1:0] OUT_RST     = '1,
   parameter logic [PIN_W-1:0] POL_RST     = '0,
   parameter logic [PIN_W-1:0] DIR_RST     = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_start,
   input  logic              host_stop,
   input  logic              host_wr_vld,
   input  logic [7:0]        host_wr_data,
   input  logic              host_rd_req,
   output logic [7:0]        host_rd_data,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe
);
   if (BYTE_W != 8) begin : g_bad_byte
      $error("gpio_xpdr_core: host byte width must be 8");
   end

   logic [BYTE_W-1:0] ptr_q;
   logic              data_wr;
   logic [PIN_W-1:0]  pin_sync;
   logic [PIN_W-1:0]  out_q;
   logic [PIN_W-1:0]  dir_q;

   gpio_xpdr_cmd u_cmd (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_start   (host_start),
      .host_stop    (host_stop),
      .host_wr_vld  (host_wr_vld),
      .host_wr_data (host_wr_data),
      .ptr_q        (ptr_q),
      .data_wr      (data_wr)
   );

   gpio_xpdr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   gpio_xpdr_regs #(
      .PIN_W   (PIN_W),
      .OUT_RST (OUT_RST),
      .POL_RST (POL_RST),
      .DIR_RST (DIR_RST)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ptr_q    (ptr_q),
      .data_wr  (data_wr),
      .wr_data  (host_wr_data),
      .rd_req   (host_rd_req),
      .pin_sync (pin_sync),
      .out_q    (out_q),
      .dir_q    (dir_q),
      .rd_data  (host_rd_data)
   );

   assign pin_oe  = ~dir_q;
   assign pin_out = out_q;

   // R8
   dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && ptr_q == 8'd3) |=> (pin_oe == ~$past(host_wr_data[PIN_W-1:0])));

   // R8
   out_to_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && ptr_q == 8'd1) |=> (pin_out == $past(host_wr_data[PIN_W-1:0])));
endmodule

// File: tb/tb_gpio_xpdr_core.sv
module tb_gpio_xpdr_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_start = 1'b0;
   logic       host_stop = 1'b0;
   logic       host_wr_vld = 1'b0;
   logic [7:0] host_wr_data = 8'h00;
   logic       host_rd_req = 1'b0;
   logic [7:0] host_rd_data;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_out;
   logic [7:0] pin_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gpio_xpdr_core dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_start   (host_start),
      .host_stop    (host_stop),
      .host_wr_vld  (host_wr_vld),
      .host_wr_data (host_wr_data),
      .host_rd_req  (host_rd_req),
      .host_rd_data (host_rd_data),
      .pin_in       (pin_in),
      .pin_out      (pin_out),
      .pin_oe       (pin_oe)
   );

   // fields: dir[31:24] pol[23:16] out[15:8] pins[7:0]
   localparam logic [31:0] VEC [6] = '{
      32'hFF_00_FF_A5,
      32'h00_FF_3C_5A,
      32'hF0_FF_0F_96,
      32'h0F_AA_C3_33,
      32'hAA_FF_55_F0,
      32'hFF_FF_00_00
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic t_start();
      host_start = 1'b1; @(negedge clk); host_start = 1'b0;
   endtask
   task automatic t_stop();
      host_stop = 1'b1; @(negedge clk); host_stop = 1'b0;
   endtask
   task automatic t_wr(input logic [7:0] b);
      host_wr_vld = 1'b1; host_wr_data = b; @(negedge clk); host_wr_vld = 1'b0;
   endtask
   task automatic t_rd(output logic [7:0] b);
      host_rd_req = 1'b1; @(negedge clk); host_rd_req = 1'b0; b = host_rd_data;
   endtask
   task automatic set_reg(input logic [7:0] p, input logic [7:0] v);
      t_start(); t_wr(p); t_wr(v); t_stop();
   endtask
   task automatic get_reg(input logic [7:0] p, output logic [7:0] v);
      t_start(); t_wr(p); t_stop(); t_rd(v);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, v2, v3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pin_oe", pin_oe, 8'h00);
      chk("R1 pin_out", pin_out, 8'hFF);
      chk("R1 rd_data", host_rd_data, 8'h00);
      get_reg(8'd3, v); chk("R1 dir", v, 8'hFF);
      get_reg(8'd2, v); chk("R1 pol", v, 8'h00);
      get_reg(8'd1, v); chk("R1 out", v, 8'hFF);

      // table walk: R2 R4 R5 R7 R8
      for (int i = 0; i < 6; i++) begin
         logic [7:0] dv, pv, ov, pins, exp_in;
         dv = VEC[i][31:24]; pv = VEC[i][23:16];
         ov = VEC[i][15:8];  pins = VEC[i][7:0];
         set_reg(8'd3, dv);
         set_reg(8'd2, pv);
         set_reg(8'd1, ov);
         pin_in = pins;
         exp_in = pins ^ (pv & dv);
         get_reg(8'd0, v);  chk("R4 R5 input view", v, exp_in);
         chk("R8 pin_oe", pin_oe, ~dv);
         chk("R8 pin_out", pin_out, ov);
         pin_in = ~ov;
         repeat (3) @(negedge clk);
         get_reg(8'd1, v);  chk("R7 latch readback", v, ov);
         get_reg(8'd2, v);  chk("R2 pol readback", v, pv);
      end

      // R4 synchronizer latency: pointer at 0, no inversion, all inputs
      set_reg(8'd3, 8'hFF);
      set_reg(8'd2, 8'h00);
      pin_in = 8'h11;
      get_reg(8'd0, v);
      pin_in = 8'hEE;
      t_rd(v); t_rd(v2); t_rd(v3);
      chk("R4 first edge old", v, 8'h11);
      chk("R4 second edge old", v2, 8'h11);
      chk("R4 third edge new", v3, 8'hEE);

      // R3 read data holds without request
      repeat (4) @(negedge clk);
      chk("R3 hold", host_rd_data, 8'hEE);

      // R6 writes to input view ignored
      set_reg(8'd1, 8'h5A);
      set_reg(8'd0, 8'h00);
      get_reg(8'd1, v); chk("R6 out kept", v, 8'h5A);
      get_reg(8'd2, v); chk("R6 pol kept", v, 8'h00);
      get_reg(8'd3, v); chk("R6 dir kept", v, 8'hFF);
      chk("R6 oe kept", pin_oe, 8'h00);

      // R9 out of range pointer
      set_reg(8'd7, 8'h00);
      t_rd(v); chk("R9 oob read zero", v, 8'h00);
      get_reg(8'd3, v); chk("R9 dir kept", v, 8'hFF);
      get_reg(8'd1, v); chk("R9 out kept", v, 8'h5A);
      get_reg(8'd2, v); chk("R9 pol kept", v, 8'h00);

      // R10 no auto advance
      t_start(); t_wr(8'd1); t_wr(8'h12); t_wr(8'h34); t_stop();
      get_reg(8'd1, v); chk("R10 last byte wins", v, 8'h34);
      get_reg(8'd2, v); chk("R10 pol untouched", v, 8'h00);
      get_reg(8'd1, v);
      t_rd(v2); chk("R10 repeat read same reg", v2, 8'h34);

      // R11 writes outside a transaction ignored, pointer kept
      get_reg(8'd2, v);
      t_wr(8'd1); t_wr(8'hC3);
      t_rd(v); chk("R11 pointer kept", v, 8'h00);
      get_reg(8'd1, v); chk("R11 out kept", v, 8'h34);
      chk("R11 pin_out kept", pin_out, 8'h34);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule